// File: doc/BRIEF.md
# Sequential Add-Shift Multiplier

This block multiplies two unsigned operands one bit at a time. It uses a single accumulator that is one bit wider than the product. When a start pulse is taken, the accumulator is loaded with the multiplier in its low half and zeros above it, and the multiplicand is captured. From then on the low bit of the accumulator chooses the next action. A 1 costs an add cycle, which places the multiplicand plus the upper half into the upper half, followed by a shift cycle. A 0 costs a shift cycle only. Each shift moves the whole accumulator one place right.

A step counter follows the shifts and raises a last-step flag once N-1 shifts are done. The shift taken while that flag is high sends the controller to a completion state. There it pulses done for one cycle and then goes back to idle. The product stays readable on the output until the next start. An operation therefore takes N plus the number of 1 bits in the multiplier active cycles, which is between N and 2N.

Top module: `add_shift_mul`

## Requirements
- R1: While reset is held, and after it is released with no start, done_o is 0 and product_o is 0.
- R2: A start_i sampled high while idle loads the operands. In the next cycle product_o[N-1:0] equals the multiplier and product_o[2N-1:N] is 0.
- R3: When done_o is high, product_o equals the unsigned product of the multiplicand and multiplier captured at start.
- R4: done_o rises N + ones(multiplier) + 1 clock edges after the edge that sampled start_i, where the start edge itself is counted as the first.
- R5: done_o is high for exactly one cycle per operation. Afterwards the block is idle and done_o stays 0 until another operation completes.
- R6: After completion and until the next accepted start, product_o holds its value whatever the operand inputs do.
- R7: A start_i that is asserted while an operation is in progress is ignored. The result and the latency of the running operation do not change.
- R8: An add cycle does no shift and no load. As a result, multiplier 2^N-1 takes 2N active cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when sampled in idle |
| mcand_i | input | N | Multiplicand |
| mplier_i | input | N | Multiplier |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 2N | Product, held after completion |

## Verification
The bench runs every one of the 256 pairs of 4-bit operands. This covers zero operands, all-ones operands and every distribution of 1 bits in the multiplier, so a wrong product is separated from a wrong choice between add and shift. Latency is compared against N plus the popcount of the multiplier. That comparison exposes a shift that is missed or added, a counter that ends one step early or late, and an add cycle that shifts by mistake. Some runs pulse start while the block is busy, which shows that such a start is ignored. Some runs change the operand inputs after completion, which shows that the held product does not move.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVAL  = 2'd1,
    ST_ADDED = 2'd2,
    ST_DONE  = 2'd3
  } mul_state_e;
endpackage

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int N = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           add_i,
  input  logic           shift_i,
  input  logic [N-1:0]   mcand_i,
  input  logic [N-1:0]   mplier_i,
  output logic           lsb_o,
  output logic [2*N-1:0] product_o
);
  localparam int AccW = 2 * N + 1;

  logic [AccW-1:0] acc_q;
  logic [N-1:0]    mcand_q;
  logic [N:0]      upper_sum;

  // Upper part plus multiplicand. The carry lands in bit N.
  assign upper_sum = acc_q[AccW-1:N] + {1'b0, mcand_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      mcand_q <= '0;
    end else if (load_i) begin
      acc_q   <= {{(N+1){1'b0}}, mplier_i};
      mcand_q <= mcand_i;
    end else if (add_i) begin
      acc_q[AccW-1:N] <= upper_sum;
    end else if (shift_i) begin
      acc_q <= {1'b0, acc_q[AccW-1:1]};
    end
  end

  assign lsb_o     = acc_q[0];
  assign product_o = acc_q[2*N-1:0];
endmodule

// File: rtl/mul_step_counter.sv
module mul_step_counter #(
  parameter int N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  output logic last_o
);
  localparam int CntW = (N > 2) ? $clog2(N) : 1;

  logic [CntW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CntW'(N - 1));
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic lsb_i,
  input  logic last_i,
  output logic load_o,
  output logic add_o,
  output logic shift_o,
  output logic done_o,
  output logic idle_o
);
  mul_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    add_o   = 1'b0;
    shift_o = 1'b0;
    done_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_d = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (lsb_i) begin
          add_o   = 1'b1;
          state_d = ST_ADDED;
        end else begin
          shift_o = 1'b1;
          state_d = last_i ? ST_DONE : ST_EVAL;
        end
      end
      ST_ADDED: begin
        shift_o = 1'b1;
        state_d = last_i ? ST_DONE : ST_EVAL;
      end
      ST_DONE: begin
        done_o  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign idle_o = (state_q == ST_IDLE);
endmodule

// File: rtl/add_shift_mul.sv
module add_shift_mul #(
  parameter int N = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N-1:0]   mcand_i,
  input  logic [N-1:0]   mplier_i,
  output logic           done_o,
  output logic [2*N-1:0] product_o
);
  logic load, add, shift, lsb, last, idle;

  mul_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .lsb_i   (lsb),
    .last_i  (last),
    .load_o  (load),
    .add_o   (add),
    .shift_o (shift),
    .done_o  (done_o),
    .idle_o  (idle)
  );

  mul_step_counter #(.N(N)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load),
    .step_i  (shift),
    .last_o  (last)
  );

  mul_datapath #(.N(N)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .add_i     (add),
    .shift_i   (shift),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .lsb_o     (lsb),
    .product_o (product_o)
  );
endmodule

// File: rtl/mul_checker.sv
module mul_checker #(
  parameter int N = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [N-1:0]   mcand_i,
  input logic [N-1:0]   mplier_i,
  input logic           load_i,
  input logic           add_i,
  input logic           shift_i,
  input logic           last_i,
  input logic           idle_i,
  input logic           done_i,
  input logic [2*N-1:0] product_i
);
  logic [2*N-1:0] a_q, b_q, exp_prod;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load_i) begin
      a_q <= {{N{1'b0}}, mcand_i};
      b_q <= {{N{1'b0}}, mplier_i};
    end
  end

  assign exp_prod = a_q * b_q;

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (product_i == b_q));

  p_done_product_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (product_i == exp_prod));

  p_last_shift_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && last_i) |=> done_i);

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (!done_i && idle_i));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && !start_i) |=> $stable(product_i));

  p_busy_no_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |-> !load_i);

  p_add_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_i |-> (!shift_i && !load_i && !done_i));
endmodule

bind add_shift_mul mul_checker #(.N(N)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .mcand_i   (mcand_i),
  .mplier_i  (mplier_i),
  .load_i    (load),
  .add_i     (add),
  .shift_i   (shift),
  .last_i    (last),
  .idle_i    (idle),
  .done_i    (done_o),
  .product_i (product_o)
);

// File: tb/add_shift_mul_tb_top.sv
`timescale 1ns/1ps
module add_shift_mul_tb_top;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N-1:0]   mcand = '0;
  logic [N-1:0]   mplier = '0;
  logic           done;
  logic [2*N-1:0] product;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int exp_prod_q[$];
  int exp_cyc_q[$];
  bit prev_done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  add_shift_mul #(.N(N)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .mcand_i   (mcand),
    .mplier_i  (mplier),
    .done_o    (done),
    .product_o (product)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Monitor: done pulses are popped against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) check("R5 done width", 1, 0);
      if (done) begin
        if (exp_prod_q.size() == 0) begin
          check("R5 unexpected done", 1, 0);
        end else begin
          check("R3 product", int'(product), exp_prod_q.pop_front());
          // R4 latency; R8 shows up as a 2N-cycle case for multiplier all ones
          check("R4/R8 latency", cyc, exp_cyc_q.pop_front());
        end
      end
      prev_done = done;
    end
  end

  task automatic run_op(input int a, input int b, input bit poke, input bit hold);
    @(negedge clk);
    mcand  = N'(a);
    mplier = N'(b);
    start  = 1'b1;
    exp_prod_q.push_back(a * b);
    exp_cyc_q.push_back(cyc + 1 + N + $countones(N'(b)));
    @(negedge clk);
    start = 1'b0;
    if (a == b || poke || hold) check("R2 load", int'(product), b);
    if (poke) begin
      mcand  = ~mcand;
      mplier = ~mplier;
      start  = 1'b1; // R7: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    if (hold) begin
      mcand  = N'(a + 3);
      mplier = N'(b + 5);
      repeat (3) @(negedge clk);
      check("R6 hold", int'(product), a * b);
      check("R5 done idle", int'(done), 0);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset done", int'(done), 0);
    check("R1 reset product", int'(product), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle done", int'(done), 0);
    check("R1 idle product", int'(product), 0);
    for (int a = 0; a < (1 << N); a++) begin
      for (int b = 0; b < (1 << N); b++) begin
        run_op(a, b, ((a + b) % 7) == 0, ((a ^ b) % 5) == 1);
      end
    end
    run_op(15, 15, 1'b1, 1'b1); // R8 all-ones: 2N active cycles
    repeat (4) @(negedge clk);
    check("R5 queue drained", exp_prod_q.size(), 0);
    finish_run();
  end
endmodule